// File: doc/BRIEF.md
# Transmit DMA Channel Tracker

This block keeps the control state of up to eight transmit DMA channels and reports it through two shared words. Each channel holds a run mode and a credit-enable bit, a one-deep request slot for the next command, and a credit counter that mirrors the free space in the transmit FIFO. From this state the block drives a per-channel internal data request. It publishes a status word with, per channel, a slot-empty flag and a no-request flag.

Channel faults are collected in a sticky error word. The faults are a command that lands on an occupied slot, and a FIFO-full indication while the credit counter still claims space. Two shared fault events are collected there as well. Software clears each error bit by writing a one to it.

Descriptor fetch and the data path are outside this block. It only sees event pulses (command, completion, data unit sent, FIFO space, FIFO full) and config and clear writes.

Top module: `txdma_chan_tracker`

## Requirements
- R1: Synchronous active-high reset puts every channel in mode off with credit disabled, an empty slot and a credit of zero. The status word reads 0xFFFF0000, the error word reads 0 and no request is raised.
- R2: A config write selects one channel by index. The channel takes its run mode from data bits 31:30 (00 off, 01 pause at end of frame, 10 normal, 11 treated as off) and its credit enable from data bit 3.
- R3: A command fills the slot only when the channel is in normal mode and the slot is empty, or is being freed by a completion in the same cycle. A completion empties the slot. A command in any other mode with an empty slot is ignored.
- R4: Status bit 24+c is 1 when channel c's slot is empty, and status bit 16+c is 1 when channel c raises no request. The status word is a register that follows the channel state one cycle later.
- R5: A channel raises its request when all of the following hold: its slot is occupied, its credit is enabled, its credit is non-zero, and its mode is normal or pause at end of frame. Switching to pause at end of frame keeps serving the occupied slot. Switching to off or 11 drops the request at once and keeps the slot.
- R6: A FIFO-space event reloads the credit to CRED_MAX. A sent data unit decrements the credit and saturates at zero. Reload wins when both happen in the same cycle.
- R7: Error bit c is set when a FIFO-full event reaches channel c while its credit is enabled and non-zero.
- R8: Error bit 9+c is set when a command reaches channel c while its slot is occupied and no completion arrives in that cycle, whatever the mode.
- R9: An address-fault event sets error bit 31 and a word-count-fault event sets error bit 30.
- R10: Error bits are sticky. A clear write removes exactly the bits written as one. A set event in the same cycle as a clear of that bit leaves it set.
- R11: Error bits 29:17 and 8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | CH_W | Channel index of the config write |
| cfg_dat | input | 32 | Config data (bits 31:30 mode, bit 3 credit enable) |
| cmd | input | NCH | Per-channel command pulse |
| done | input | NCH | Per-channel completion pulse |
| sent | input | NCH | Per-channel data-unit-sent pulse |
| space | input | NCH | Per-channel FIFO-space (credit reload) pulse |
| full | input | NCH | Per-channel FIFO-full pulse |
| addr_flt | input | 1 | Address fault event |
| wcnt_flt | input | 1 | Word-count fault event |
| clr_we | input | 1 | Error clear write strobe |
| clr_dat | input | 32 | Error clear mask, a one clears the bit |
| dma_req | output | NCH | Per-channel internal data request |
| status | output | 32 | Shared status word |
| err | output | 32 | Shared sticky error word |

## Verification
The channels are driven through a sequence of single-event steps that walk the credit from reload down past zero, which separates the saturating decrement from a wrap and shows when the request drops. Commands are issued in each run mode and against full and empty slots, which tells ignored commands apart from accepted ones and from overruns. Coincident events are tried on purpose to pin down each priority rule: completion with command, reload with decrement, set with clear. Clear masks of all zeros, one bit and all ones show that clearing is bit-exact.

// File: rtl/txdma_trk_pkg.sv
package txdma_trk_pkg;
  typedef enum logic [1:0] {
    RUN_OFF       = 2'b00,
    RUN_PAUSE_EOF = 2'b01,
    RUN_NORMAL    = 2'b10,
    RUN_RSVD      = 2'b11
  } run_mode_e;

  localparam int MODE_HI        = 31;
  localparam int MODE_LO        = 30;
  localparam int CRED_EN_BIT    = 3;
  localparam int ERR_ADDR_BIT   = 31;
  localparam int ERR_WCNT_BIT   = 30;
  localparam int ERR_OVR_BASE   = 9;
  localparam int ERR_CRED_BASE  = 0;
  localparam int ST_EMPTY_BASE  = 24;
  localparam int ST_NOREQ_BASE  = 16;
  localparam logic [31:0] ERR_RSV_MASK = 32'h3FFE_0100;
endpackage

// File: rtl/txdma_chan.sv
module txdma_chan
  import txdma_trk_pkg::*;
#(
  parameter int CRED_MAX = 3,
  localparam int CRED_W = $clog2(CRED_MAX + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  run_mode_e cfg_mode,
  input  logic      cfg_cen,
  input  logic      cmd,
  input  logic      done,
  input  logic      sent,
  input  logic      space,
  input  logic      full,
  output logic      slot_full,
  output logic      req,
  output logic      ovr_evt,
  output logic      cred_evt
);
  run_mode_e         mode_q;
  logic              cen_q;
  logic              slot_q;
  logic [CRED_W-1:0] cred_q;
  logic              accept;
  logic              serving;
  logic              cred_nz;

  assign cred_nz = (cred_q != '0);
  assign serving = (mode_q == RUN_NORMAL) || (mode_q == RUN_PAUSE_EOF);
  assign accept  = cmd && (mode_q == RUN_NORMAL) && (!slot_q || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RUN_OFF;
      cen_q  <= 1'b0;
      slot_q <= 1'b0;
      cred_q <= '0;
    end else begin
      if (cfg_we) begin
        mode_q <= cfg_mode;
        cen_q  <= cfg_cen;
      end
      if (accept)      slot_q <= 1'b1;
      else if (done)   slot_q <= 1'b0;
      if (space)                 cred_q <= CRED_W'(CRED_MAX);
      else if (sent && cred_nz)  cred_q <= cred_q - 1'b1;
    end
  end

  assign slot_full = slot_q;
  assign req       = slot_q && cen_q && cred_nz && serving;
  assign ovr_evt   = cmd && slot_q && !done;
  assign cred_evt  = full && cen_q && cred_nz;

  assert_credit_cap_R6: assert property (@(posedge clk) disable iff (rst)
    cred_q <= CRED_W'(CRED_MAX));
  assert_credit_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (sent && !space && cred_q == '0) |=> (cred_q == '0));
  assert_credit_reload_R6: assert property (@(posedge clk) disable iff (rst)
    space |=> (cred_q == CRED_W'(CRED_MAX)));
  assert_accept_mode_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_q) |-> ($past(mode_q) == RUN_NORMAL));
  assert_slot_free_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd) |=> !slot_q);
endmodule

// File: rtl/txdma_w1c_bank.sv
module txdma_w1c_bank #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RSV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= ((q_o & ~clr_eff) | set_i) & ~RSV;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & ~RSV)) |=> ((q_o & $past(set_i & ~RSV)) == $past(set_i & ~RSV)));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> (($past(q_o) & ~q_o) == '0));
  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (q_o & RSV) == '0);
endmodule

// File: rtl/txdma_chan_tracker.sv
module txdma_chan_tracker
  import txdma_trk_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CRED_MAX = 3,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CH_W-1:0] cfg_ch,
  input  logic [31:0]     cfg_dat,
  input  logic [NCH-1:0]  cmd,
  input  logic [NCH-1:0]  done,
  input  logic [NCH-1:0]  sent,
  input  logic [NCH-1:0]  space,
  input  logic [NCH-1:0]  full,
  input  logic            addr_flt,
  input  logic            wcnt_flt,
  input  logic            clr_we,
  input  logic [31:0]     clr_dat,
  output logic [NCH-1:0]  dma_req,
  output logic [31:0]     status,
  output logic [31:0]     err
);
  logic [NCH-1:0] slot_full;
  logic [NCH-1:0] ovr_evt;
  logic [NCH-1:0] cred_evt;
  logic [31:0]    err_set;
  logic [31:0]    st_d;
  run_mode_e      wr_mode;

  assign wr_mode = run_mode_e'(cfg_dat[MODE_HI:MODE_LO]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    txdma_chan #(.CRED_MAX(CRED_MAX)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we && (cfg_ch == CH_W'(c))),
      .cfg_mode (wr_mode),
      .cfg_cen  (cfg_dat[CRED_EN_BIT]),
      .cmd      (cmd[c]),
      .done     (done[c]),
      .sent     (sent[c]),
      .space    (space[c]),
      .full     (full[c]),
      .slot_full(slot_full[c]),
      .req      (dma_req[c]),
      .ovr_evt  (ovr_evt[c]),
      .cred_evt (cred_evt[c])
    );
  end

  always_comb begin
    err_set = '0;
    st_d    = '0;
    err_set[ERR_ADDR_BIT] = addr_flt;
    err_set[ERR_WCNT_BIT] = wcnt_flt;
    for (int c = 0; c < NCH; c++) begin
      err_set[ERR_OVR_BASE + c]  = ovr_evt[c];
      err_set[ERR_CRED_BASE + c] = cred_evt[c];
      st_d[ST_EMPTY_BASE + c]    = !slot_full[c];
      st_d[ST_NOREQ_BASE + c]    = !dma_req[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      for (int c = 0; c < NCH; c++) begin
        status[ST_EMPTY_BASE + c] <= 1'b1;
        status[ST_NOREQ_BASE + c] <= 1'b1;
      end
    end else begin
      status <= st_d;
    end
  end

  txdma_w1c_bank #(.W(32), .RSV(ERR_RSV_MASK)) u_err (
    .clk   (clk),
    .rst   (rst),
    .set_i (err_set),
    .clr_we(clr_we),
    .clr_i (clr_dat),
    .q_o   (err)
  );

  assert_addr_flt_R9: assert property (@(posedge clk) disable iff (rst)
    addr_flt |=> err[ERR_ADDR_BIT]);
  assert_wcnt_flt_R9: assert property (@(posedge clk) disable iff (rst)
    wcnt_flt |=> err[ERR_WCNT_BIT]);
  assert_req_needs_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (dma_req & ~slot_full) == '0);
endmodule

// File: tb/txdma_chan_tracker_bench.sv
module txdma_chan_tracker_bench;
  localparam int NCH = 8;

  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  ch;
    logic [31:0] dat;
    logic [31:0] st;
    logic [31:0] er;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [3:0] OP_CMD = 0, OP_CFG = 1, OP_DONE = 2, OP_SENT = 3,
    OP_SPACE = 4, OP_FULL = 5, OP_AERR = 6, OP_WERR = 7, OP_CLR = 8;
  localparam int NV = 31;
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_CMD,   3'd0, 32'h0,        32'hFFFF0000, 32'h0,        8'h00},
    '{OP_CFG,   3'd0, 32'h80000008, 32'hFFFF0000, 32'h0,        8'h00},
    '{OP_CMD,   3'd0, 32'h0,        32'hFEFF0000, 32'h0,        8'h00},
    '{OP_SPACE, 3'd0, 32'h0,        32'hFEFE0000, 32'h0,        8'h01},
    '{OP_SENT,  3'd0, 32'h0,        32'hFEFE0000, 32'h0,        8'h01},
    '{OP_FULL,  3'd0, 32'h0,        32'hFEFE0000, 32'h1,        8'h01},
    '{OP_CMD,   3'd0, 32'h0,        32'hFEFE0000, 32'h201,      8'h01},
    '{OP_SENT,  3'd0, 32'h0,        32'hFEFE0000, 32'h201,      8'h01},
    '{OP_SENT,  3'd0, 32'h0,        32'hFEFF0000, 32'h201,      8'h00},
    '{OP_SENT,  3'd0, 32'h0,        32'hFEFF0000, 32'h201,      8'h00},
    '{OP_FULL,  3'd0, 32'h0,        32'hFEFF0000, 32'h201,      8'h00},
    '{OP_DONE,  3'd0, 32'h0,        32'hFFFF0000, 32'h201,      8'h00},
    '{OP_CFG,   3'd3, 32'h40000008, 32'hFFFF0000, 32'h201,      8'h00},
    '{OP_CMD,   3'd3, 32'h0,        32'hFFFF0000, 32'h201,      8'h00},
    '{OP_CFG,   3'd3, 32'h80000008, 32'hFFFF0000, 32'h201,      8'h00},
    '{OP_CMD,   3'd3, 32'h0,        32'hF7FF0000, 32'h201,      8'h00},
    '{OP_SPACE, 3'd3, 32'h0,        32'hF7F70000, 32'h201,      8'h08},
    '{OP_CFG,   3'd3, 32'h40000008, 32'hF7F70000, 32'h201,      8'h08},
    '{OP_CMD,   3'd3, 32'h0,        32'hF7F70000, 32'h1201,     8'h08},
    '{OP_CFG,   3'd3, 32'h00000008, 32'hF7FF0000, 32'h1201,     8'h00},
    '{OP_CFG,   3'd3, 32'hC0000008, 32'hF7FF0000, 32'h1201,     8'h00},
    '{OP_DONE,  3'd3, 32'h0,        32'hFFFF0000, 32'h1201,     8'h00},
    '{OP_AERR,  3'd0, 32'h0,        32'hFFFF0000, 32'h80001201, 8'h00},
    '{OP_WERR,  3'd0, 32'h0,        32'hFFFF0000, 32'hC0001201, 8'h00},
    '{OP_CLR,   3'd0, 32'h00000200, 32'hFFFF0000, 32'hC0001001, 8'h00},
    '{OP_CLR,   3'd0, 32'h00000000, 32'hFFFF0000, 32'hC0001001, 8'h00},
    '{OP_CLR,   3'd0, 32'hFFFFFFFF, 32'hFFFF0000, 32'h0,        8'h00},
    '{OP_CFG,   3'd5, 32'h80000000, 32'hFFFF0000, 32'h0,        8'h00},
    '{OP_CMD,   3'd5, 32'h0,        32'hDFFF0000, 32'h0,        8'h00},
    '{OP_SPACE, 3'd5, 32'h0,        32'hDFFF0000, 32'h0,        8'h00},
    '{OP_FULL,  3'd5, 32'h0,        32'hDFFF0000, 32'h0,        8'h00}
  };
  localparam string REQ_OF [0:8] = '{"R3 R8", "R2 R5", "R3 R4", "R5 R6", "R6",
    "R7", "R9", "R9", "R10"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, addr_flt = 1'b0, wcnt_flt = 1'b0, clr_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [31:0] cfg_dat = '0, clr_dat = '0;
  logic [NCH-1:0] cmd = '0, done = '0, sent = '0, space = '0, full = '0;
  logic [NCH-1:0] dma_req;
  logic [31:0] status, err;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txdma_chan_tracker u_txdma_chan_tracker (
    .clk, .rst, .cfg_we, .cfg_ch, .cfg_dat, .cmd, .done, .sent, .space, .full,
    .addr_flt, .wcnt_flt, .clr_we, .clr_dat, .dma_req, .status, .err);

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; addr_flt = 0; wcnt_flt = 0; clr_we = 0;
    cmd = '0; done = '0; sent = '0; space = '0; full = '0;
  endtask

  task automatic finish_step();
    @(negedge clk); idle_inputs();
    @(negedge clk);
  endtask

  task automatic apply(logic [3:0] op, logic [2:0] ch, logic [31:0] dat);
    @(negedge clk);
    case (op)
      OP_CMD:   cmd[ch] = 1'b1;
      OP_CFG:   begin cfg_we = 1'b1; cfg_ch = ch; cfg_dat = dat; end
      OP_DONE:  done[ch] = 1'b1;
      OP_SENT:  sent[ch] = 1'b1;
      OP_SPACE: space[ch] = 1'b1;
      OP_FULL:  full[ch] = 1'b1;
      OP_AERR:  addr_flt = 1'b1;
      OP_WERR:  wcnt_flt = 1'b1;
      OP_CLR:   begin clr_we = 1'b1; clr_dat = dat; end
      default:  ;
    endcase
    finish_step();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "reset status", status, 32'hFFFF0000);
    chk("R1", "reset err", err, 32'h0);
    chk("R1", "reset req", {24'h0, dma_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].ch, VEC[i].dat);
      chk(REQ_OF[VEC[i].op], $sformatf("vec %0d status", i), status, VEC[i].st);
      chk(REQ_OF[VEC[i].op], $sformatf("vec %0d err", i), err, VEC[i].er);
      chk(REQ_OF[VEC[i].op], $sformatf("vec %0d req", i), {24'h0, dma_req}, {24'h0, VEC[i].rq});
    end

    // R10: set and clear of bit 3 in the same cycle, set wins
    @(negedge clk); full[3] = 1'b1; clr_we = 1'b1; clr_dat = 32'h8;
    finish_step();
    chk("R10", "set beats clear", err, 32'h8);

    // R3 R8: command with completion on an occupied slot, no overrun, slot refilled
    @(negedge clk); cmd[5] = 1'b1; done[5] = 1'b1;
    finish_step();
    chk("R8", "cmd with done no overrun", err, 32'h8);
    chk("R3", "slot refilled", status, 32'hDFFF0000);

    // R6 R7: reload beats decrement on ch0 (credit was 0), then full flags it
    @(negedge clk); sent[0] = 1'b1; space[0] = 1'b1;
    finish_step();
    apply(OP_FULL, 3'd0, 32'h0);
    chk("R6", "reload wins then credit error", err, 32'h9);

    // R11: reserved bits stay zero after every fault source fires
    @(negedge clk); addr_flt = 1'b1; wcnt_flt = 1'b1; full = 8'hFF; cmd = 8'hFF;
    finish_step();
    chk("R11", "reserved bits", err & 32'h3FFE0100, 32'h0);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R1", "re-reset status", status, 32'hFFFF0000);
    chk("R1", "re-reset err", err, 32'h0);
    chk("R1", "re-reset req", {24'h0, dma_req}, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule